// File: doc/BRIEF.md
# Shared DMA Port Arbiter

This block shares one memory DMA port between a receive engine and a transmit engine. Each engine raises a request that names a direction (read or write), an address and a byte length. If the port is free, the transfer starts at once. If another transfer holds the port, the requesting engine parks in a waiting state that matches the kind of transfer it asked for. Only one transfer owns the port at a time.

The block does not move any data. It models how long each transfer takes. A transfer occupies the port for a fixed delay plus a per-64-byte factor times the length rounded up to whole 64-byte blocks. The delay and the factor are chosen separately for reads and writes. When a transfer ends, the owning engine returns to idle and receives a one-cycle done pulse. A request parked by the other engine is served before the finishing engine can take the port again. The port fields show which transfer was started most recently, so that a downstream memory model can follow along.

Top module: `dma_port_arbiter`

## Requirements
- R1: While and just after reset, both engine states read idle and both done outputs are low.
- R2: The engine state outputs use this encoding: 0 idle, 1 reading, 2 writing, 3 read-waiting, 4 write-waiting. A request bit `*Write` of 1 means a write and 0 means a read.
- R3: The latency L of a transfer is the delay plus ceil(len/64) times the factor, using the read pair or the write pair of configuration inputs. A transfer with L of at least 1 that is started at clock edge E holds its engine in reading or writing until edge E+L. At that edge the engine returns to idle and its done output goes high for exactly one cycle.
- R4: A transfer with L equal to 0 completes at its start edge. The engine stays idle and its done output goes high for the following cycle.
- R5: A request that arrives while the other engine owns the port moves the requester to read-waiting or write-waiting, according to its write bit.
- R6: A request is ignored while its engine is reading or writing, and while it waits for the other kind of transfer. The state does not change, and the running transfer keeps its original latency.
- R7: A same-kind request from a waiting engine replaces the parked address and length. These new values are used when the transfer starts.
- R8: Once the port is released, a waiting engine is started at the next clock edge, ahead of any new request from the engine that just finished. That new request then parks.
- R9: If both engines request at the same edge while the port is free and neither is waiting, receive starts and transmit parks.
- R10: At every start edge, `portAddr`, `portLen`, `portWrite` and `portOwnerTx` take the address, length, direction and engine of the transfer that starts (`portOwnerTx` is 1 for transmit).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| rxReq | input | 1 | Receive engine request |
| rxWrite | input | 1 | Receive request is a write (1) or a read (0) |
| rxAddr | input | AW | Receive request address |
| rxLen | input | LW | Receive request length in bytes |
| txReq | input | 1 | Transmit engine request |
| txWrite | input | 1 | Transmit request is a write (1) or a read (0) |
| txAddr | input | AW | Transmit request address |
| txLen | input | LW | Transmit request length in bytes |
| rdDelay | input | DW | Fixed cycles added to every read |
| rdFactor | input | DW | Cycles per 64-byte block of a read |
| wrDelay | input | DW | Fixed cycles added to every write |
| wrFactor | input | DW | Cycles per 64-byte block of a write |
| rxState | output | 3 | Receive engine state (encoding in R2) |
| txState | output | 3 | Transmit engine state (encoding in R2) |
| rxDone | output | 1 | One-cycle completion pulse for receive |
| txDone | output | 1 | One-cycle completion pulse for transmit |
| portAddr | output | AW | Address of the most recently started transfer |
| portLen | output | LW | Length of the most recently started transfer |
| portWrite | output | 1 | Direction of the most recently started transfer |
| portOwnerTx | output | 1 | Most recently started transfer belongs to transmit |

## Verification
The hardest situation to reach is the release of the port while the other engine is parked and the finishing engine asks again in the very same cycle. The stimulus parks transmit behind a long receive write. It watches for the receive done pulse and drives a fresh receive request in exactly that cycle. The next edge must start transmit and park receive. A second hard case is a waiting engine that gets a request of the wrong kind and then one of the right kind. This is reached by holding the port with a transmit write while receive is parked. The later start must carry the replacement length and the latency that length implies.

// File: rtl/dma_arb_pkg.sv
package dma_arb_pkg;

  typedef enum logic [2:0] {
    ENG_IDLE   = 3'd0,
    ENG_READ   = 3'd1,
    ENG_WRITE  = 3'd2,
    ENG_RDWAIT = 3'd3,
    ENG_WRWAIT = 3'd4
  } engState_t;

  // strobes from control to datapath
  typedef struct packed {
    logic parkRx;   // capture live receive request into parked slot
    logic parkTx;   // capture live transmit request into parked slot
    logic startRx;  // receive takes the port this edge
    logic startTx;  // transmit takes the port this edge
    logic srcLive;  // started transfer uses live inputs, not parked slot
  } arbStrobe_t;

endpackage

// File: rtl/dma_arb_ctrl.sv
module dma_arb_ctrl
  import dma_arb_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       rxReq,
  input  logic       rxWrite,
  input  logic       txReq,
  input  logic       txWrite,
  input  logic       latZero,
  input  logic       cntLast,
  output arbStrobe_t strobe,
  output engState_t  rxState,
  output engState_t  txState,
  output logic       rxDone,
  output logic       txDone
);

  logic rxActive, txActive, rxWaiting, txWaiting, busy;
  logic rxAccept, txAccept, startRx, startTx;
  logic rxKindW, txKindW;
  engState_t rxNext, txNext;
  logic rxDoneNext, txDoneNext;

  assign rxActive  = (rxState == ENG_READ) || (rxState == ENG_WRITE);
  assign txActive  = (txState == ENG_READ) || (txState == ENG_WRITE);
  assign rxWaiting = (rxState == ENG_RDWAIT) || (rxState == ENG_WRWAIT);
  assign txWaiting = (txState == ENG_RDWAIT) || (txState == ENG_WRWAIT);
  assign busy      = rxActive || txActive;

  assign rxAccept = rxReq && ((rxState == ENG_IDLE) ||
                              (rxState == ENG_RDWAIT && !rxWrite) ||
                              (rxState == ENG_WRWAIT && rxWrite));
  assign txAccept = txReq && ((txState == ENG_IDLE) ||
                              (txState == ENG_RDWAIT && !txWrite) ||
                              (txState == ENG_WRWAIT && txWrite));

  // a parked engine beats any fresh request; receive beats transmit
  assign startRx = !busy && (rxWaiting || (rxAccept && !txWaiting));
  assign startTx = !busy && !startRx && (txWaiting || txAccept);

  assign rxKindW = rxAccept ? rxWrite : (rxState == ENG_WRWAIT);
  assign txKindW = txAccept ? txWrite : (txState == ENG_WRWAIT);

  assign strobe.parkRx  = rxAccept && !startRx;
  assign strobe.parkTx  = txAccept && !startTx;
  assign strobe.startRx = startRx;
  assign strobe.startTx = startTx;
  assign strobe.srcLive = startTx ? txAccept : rxAccept;

  always_comb begin
    rxNext = rxState;
    rxDoneNext = 1'b0;
    if (startRx) begin
      if (latZero) begin
        rxNext = ENG_IDLE;
        rxDoneNext = 1'b1;
      end else begin
        rxNext = rxKindW ? ENG_WRITE : ENG_READ;
      end
    end else if (strobe.parkRx) begin
      rxNext = rxWrite ? ENG_WRWAIT : ENG_RDWAIT;
    end else if (rxActive && cntLast) begin
      rxNext = ENG_IDLE;
      rxDoneNext = 1'b1;
    end
  end

  always_comb begin
    txNext = txState;
    txDoneNext = 1'b0;
    if (startTx) begin
      if (latZero) begin
        txNext = ENG_IDLE;
        txDoneNext = 1'b1;
      end else begin
        txNext = txKindW ? ENG_WRITE : ENG_READ;
      end
    end else if (strobe.parkTx) begin
      txNext = txWrite ? ENG_WRWAIT : ENG_RDWAIT;
    end else if (txActive && cntLast) begin
      txNext = ENG_IDLE;
      txDoneNext = 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rxState <= ENG_IDLE;
      txState <= ENG_IDLE;
      rxDone  <= 1'b0;
      txDone  <= 1'b0;
    end else begin
      rxState <= rxNext;
      txState <= txNext;
      rxDone  <= rxDoneNext;
      txDone  <= txDoneNext;
    end
  end

  // R8: the port never has two owners
  p_single_owner_r8: assert property (@(posedge clk) disable iff (!rstN)
    !(rxActive && txActive));

  // R3: a done pulse is only seen with the engine back at idle
  p_rx_done_idle_r3: assert property (@(posedge clk) disable iff (!rstN)
    rxDone |-> (rxState == ENG_IDLE));
  p_tx_done_idle_r3: assert property (@(posedge clk) disable iff (!rstN)
    txDone |-> (txState == ENG_IDLE));

  // R8: a parked engine is served as soon as the port is free
  p_rx_wait_served_r8: assert property (@(posedge clk) disable iff (!rstN)
    (rxWaiting && !busy) |=> !((rxState == ENG_RDWAIT) || (rxState == ENG_WRWAIT)));
  p_tx_wait_served_r8: assert property (@(posedge clk) disable iff (!rstN)
    (txWaiting && !busy) |=> !((txState == ENG_RDWAIT) || (txState == ENG_WRWAIT)));

  // R9: simultaneous fresh requests on a free port park transmit
  p_rx_first_r9: assert property (@(posedge clk) disable iff (!rstN)
    (rxState == ENG_IDLE && txState == ENG_IDLE && rxReq && txReq)
      |=> ((txState == ENG_RDWAIT) || (txState == ENG_WRWAIT)));

  // R6: an active engine only holds its state or finishes
  p_rx_hold_r6: assert property (@(posedge clk) disable iff (!rstN)
    rxActive |=> ((rxState == $past(rxState)) || (rxState == ENG_IDLE)));

endmodule

// File: rtl/dma_arb_path.sv
module dma_arb_path
  import dma_arb_pkg::*;
#(
  parameter int AW = 32,
  parameter int LW = 14,
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          rstN,
  input  arbStrobe_t    strobe,
  input  logic [AW-1:0] rxAddr,
  input  logic [LW-1:0] rxLen,
  input  logic          rxWrite,
  input  logic [AW-1:0] txAddr,
  input  logic [LW-1:0] txLen,
  input  logic          txWrite,
  input  logic [DW-1:0] rdDelay,
  input  logic [DW-1:0] rdFactor,
  input  logic [DW-1:0] wrDelay,
  input  logic [DW-1:0] wrFactor,
  output logic          latZero,
  output logic          cntLast,
  output logic          cntIdle,
  output logic [AW-1:0] portAddr,
  output logic [LW-1:0] portLen,
  output logic          portWrite,
  output logic          portOwnerTx
);

  localparam int NENG  = 2;
  localparam int BLKW  = LW - 5;        // holds ceil(max len / 64)
  localparam int PRODW = BLKW + DW;
  localparam int CW    = PRODW + 1;     // delay + product without overflow

  logic [NENG-1:0][AW-1:0] liveAddr, parkAddr;
  logic [NENG-1:0][LW-1:0] liveLen, parkLen;
  logic [NENG-1:0]         liveWrite, parkWrite, park;

  assign liveAddr  = {txAddr, rxAddr};
  assign liveLen   = {txLen, rxLen};
  assign liveWrite = {txWrite, rxWrite};
  assign park      = {strobe.parkTx, strobe.parkRx};

  always_ff @(posedge clk) begin
    if (!rstN) begin
      parkAddr  <= '0;
      parkLen   <= '0;
      parkWrite <= '0;
    end else begin
      for (int e = 0; e < NENG; e++) begin
        if (park[e]) begin
          parkAddr[e]  <= liveAddr[e];
          parkLen[e]   <= liveLen[e];
          parkWrite[e] <= liveWrite[e];
        end
      end
    end
  end

  logic          selIdx, anyStart, selWrite;
  logic [AW-1:0] selAddr;
  logic [LW-1:0] selLen;
  logic [LW:0]   lenRound;
  logic [BLKW-1:0] blocks;
  logic [DW-1:0] selDelay, selFactor;
  logic [PRODW-1:0] prod;
  logic [CW-1:0] lat, cnt;

  assign selIdx   = strobe.startTx;
  assign anyStart = strobe.startRx || strobe.startTx;
  assign selAddr  = strobe.srcLive ? liveAddr[selIdx]  : parkAddr[selIdx];
  assign selLen   = strobe.srcLive ? liveLen[selIdx]   : parkLen[selIdx];
  assign selWrite = strobe.srcLive ? liveWrite[selIdx] : parkWrite[selIdx];

  assign lenRound  = {1'b0, selLen} + (LW+1)'(63);
  assign blocks    = BLKW'(lenRound >> 6);
  assign selDelay  = selWrite ? wrDelay : rdDelay;
  assign selFactor = selWrite ? wrFactor : rdFactor;
  assign prod      = PRODW'(blocks) * PRODW'(selFactor);
  assign lat       = CW'(prod) + CW'(selDelay);
  assign latZero   = (lat == '0);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      cnt         <= '0;
      portAddr    <= '0;
      portLen     <= '0;
      portWrite   <= 1'b0;
      portOwnerTx <= 1'b0;
    end else if (anyStart) begin
      cnt         <= lat;
      portAddr    <= selAddr;
      portLen     <= selLen;
      portWrite   <= selWrite;
      portOwnerTx <= selIdx;
    end else if (cnt != '0) begin
      cnt <= cnt - 1'b1;
    end
  end

  assign cntLast = (cnt == CW'(1));
  assign cntIdle = (cnt == '0);

  // R10: port fields only move at a start edge
  p_port_stable_r10: assert property (@(posedge clk) disable iff (!rstN)
    !anyStart |=> $stable(portLen) && $stable(portOwnerTx));

endmodule

// File: rtl/dma_port_arbiter.sv
module dma_port_arbiter
  import dma_arb_pkg::*;
#(
  parameter int AW = 32,
  parameter int LW = 14,
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          rxReq,
  input  logic          rxWrite,
  input  logic [AW-1:0] rxAddr,
  input  logic [LW-1:0] rxLen,
  input  logic          txReq,
  input  logic          txWrite,
  input  logic [AW-1:0] txAddr,
  input  logic [LW-1:0] txLen,
  input  logic [DW-1:0] rdDelay,
  input  logic [DW-1:0] rdFactor,
  input  logic [DW-1:0] wrDelay,
  input  logic [DW-1:0] wrFactor,
  output logic [2:0]    rxState,
  output logic [2:0]    txState,
  output logic          rxDone,
  output logic          txDone,
  output logic [AW-1:0] portAddr,
  output logic [LW-1:0] portLen,
  output logic          portWrite,
  output logic          portOwnerTx
);

  arbStrobe_t strobe;
  engState_t  rxSt, txSt;
  logic latZero, cntLast, cntIdle;

  dma_arb_ctrl u_ctrl (
    .clk     (clk),
    .rstN    (rstN),
    .rxReq   (rxReq),
    .rxWrite (rxWrite),
    .txReq   (txReq),
    .txWrite (txWrite),
    .latZero (latZero),
    .cntLast (cntLast),
    .strobe  (strobe),
    .rxState (rxSt),
    .txState (txSt),
    .rxDone  (rxDone),
    .txDone  (txDone)
  );

  dma_arb_path #(.AW(AW), .LW(LW), .DW(DW)) u_path (
    .clk         (clk),
    .rstN        (rstN),
    .strobe      (strobe),
    .rxAddr      (rxAddr),
    .rxLen       (rxLen),
    .rxWrite     (rxWrite),
    .txAddr      (txAddr),
    .txLen       (txLen),
    .txWrite     (txWrite),
    .rdDelay     (rdDelay),
    .rdFactor    (rdFactor),
    .wrDelay     (wrDelay),
    .wrFactor    (wrFactor),
    .latZero     (latZero),
    .cntLast     (cntLast),
    .cntIdle     (cntIdle),
    .portAddr    (portAddr),
    .portLen     (portLen),
    .portWrite   (portWrite),
    .portOwnerTx (portOwnerTx)
  );

  assign rxState = rxSt;
  assign txState = txSt;

  // R3: an engine in reading or writing always has cycles left to run
  p_count_live_r3: assert property (@(posedge clk) disable iff (!rstN)
    ((rxSt == ENG_READ) || (rxSt == ENG_WRITE) ||
     (txSt == ENG_READ) || (txSt == ENG_WRITE)) |-> !cntIdle);

endmodule

// File: tb/sim_dma_port_arbiter.sv
`timescale 1ns/1ps
module sim_dma_port_arbiter;

  logic        clk = 1'b0;
  logic        rstN;
  logic        rxReq, rxWrite, txReq, txWrite;
  logic [31:0] rxAddr, txAddr;
  logic [13:0] rxLen, txLen;
  logic [15:0] rdDelay, rdFactor, wrDelay, wrFactor;
  logic [2:0]  rxState, txState;
  logic        rxDone, txDone;
  logic [31:0] portAddr;
  logic [13:0] portLen;
  logic        portWrite, portOwnerTx;

  int total = 0;
  int bad = 0;
  int cycles = 0;

  always #2.5 clk = ~clk;

  dma_port_arbiter u0 (
    .clk(clk), .rstN(rstN),
    .rxReq(rxReq), .rxWrite(rxWrite), .rxAddr(rxAddr), .rxLen(rxLen),
    .txReq(txReq), .txWrite(txWrite), .txAddr(txAddr), .txLen(txLen),
    .rdDelay(rdDelay), .rdFactor(rdFactor), .wrDelay(wrDelay), .wrFactor(wrFactor),
    .rxState(rxState), .txState(txState), .rxDone(rxDone), .txDone(txDone),
    .portAddr(portAddr), .portLen(portLen), .portWrite(portWrite),
    .portOwnerTx(portOwnerTx)
  );

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      bad++;
      total++;
      $display("FAIL watchdog: actual=%0d cycles expected=<150000", cycles);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  task automatic chk(input string what, input longint act, input longint exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", what, act, exp);
    end
  endtask

  function automatic longint expLat(input longint d, input longint f, input longint len);
    return d + ((len + 63) / 64) * f;
  endfunction

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  // tick once with the current requests, then drop them
  task automatic issue();
    tick();
    rxReq = 1'b0;
    txReq = 1'b0;
  endtask

  task automatic waitDone(input bit isTx, output int n);
    n = 0;
    while (!(isTx ? txDone : rxDone) && n < 60000) begin
      tick();
      n++;
    end
  endtask

  task automatic t_reset();
    rstN = 1'b0;
    rxReq = 0; txReq = 0; rxWrite = 0; txWrite = 0;
    rxAddr = 0; txAddr = 0; rxLen = 0; txLen = 0;
    rdDelay = 3; rdFactor = 2; wrDelay = 1; wrFactor = 5;
    repeat (3) tick();
    chk("R1 rx state in reset", rxState, 0);
    chk("R1 tx state in reset", txState, 0);
    chk("R1 done low in reset", {rxDone, txDone}, 0);
    rstN = 1'b1;
    tick();
    chk("R1 idle after reset", {rxState, txState}, 0);
  endtask

  task automatic t_rx_read();
    int n;
    rxReq = 1; rxWrite = 0; rxAddr = 32'h1000; rxLen = 100;
    issue();
    chk("R2 rx reading code", rxState, 1);
    chk("R10 port length", portLen, 100);
    chk("R10 port address", portAddr, 32'h1000);
    chk("R10 port owner rx", portOwnerTx, 0);
    chk("R10 port direction read", portWrite, 0);
    waitDone(0, n);
    chk("R3 rx read latency", n, expLat(3, 2, 100));
    chk("R3 rx idle at done", rxState, 0);
    tick();
    chk("R3 done lasts one cycle", rxDone, 0);
  endtask

  task automatic t_tx_write();
    int n;
    txReq = 1; txWrite = 1; txAddr = 32'h2040; txLen = 64;
    issue();
    chk("R2 tx writing code", txState, 2);
    chk("R10 port owner tx", portOwnerTx, 1);
    chk("R10 port direction write", portWrite, 1);
    waitDone(1, n);
    chk("R3 tx write len 64", n, expLat(1, 5, 64));
    tick();
    txReq = 1; txLen = 65;
    issue();
    waitDone(1, n);
    chk("R3 tx write len 65 rounds up", n, expLat(1, 5, 65));
    tick();
  endtask

  task automatic t_zero();
    rdDelay = 0; rdFactor = 9;
    rxReq = 1; rxWrite = 0; rxLen = 0;
    issue();
    chk("R4 zero latency done", rxDone, 1);
    chk("R4 zero latency stays idle", rxState, 0);
    tick();
    chk("R4 zero latency pulse ends", rxDone, 0);
    rdDelay = 3; rdFactor = 2;
  endtask

  task automatic t_simultaneous();
    int n;
    rxReq = 1; rxWrite = 0; rxLen = 64;
    txReq = 1; txWrite = 1; txLen = 64; txAddr = 32'h3000;
    issue();
    chk("R9 rx wins", rxState, 1);
    chk("R9 tx parks write-waiting", txState, 4);
    waitDone(0, n);
    chk("R3 rx latency with tx parked", n, expLat(3, 2, 64));
    chk("R8 tx still parked at rx done", txState, 4);
    tick();
    chk("R8 tx started after release", txState, 2);
    chk("R10 port address from parked tx", portAddr, 32'h3000);
    waitDone(1, n);
    chk("R3 parked tx latency", n, expLat(1, 5, 64));
    tick();
  endtask

  task automatic t_handoff();
    int n;
    rxReq = 1; rxWrite = 1; rxLen = 128;
    issue();
    txReq = 1; txWrite = 0; txLen = 64;
    issue();
    chk("R5 tx read-waiting behind rx", txState, 3);
    waitDone(0, n);
    rxReq = 1; rxWrite = 0; rxLen = 64;
    issue();
    chk("R8 tx served first", txState, 1);
    chk("R8 finisher request parks", rxState, 3);
    waitDone(1, n);
    chk("R3 tx read latency", n, expLat(3, 2, 64));
    tick();
    chk("R8 rx starts after tx", rxState, 1);
    waitDone(0, n);
    tick();
  endtask

  task automatic t_ignore();
    int n;
    rxReq = 1; rxWrite = 0; rxLen = 640;
    tick();
    rxWrite = 1; rxLen = 64;
    tick();
    rxReq = 0;
    chk("R6 request ignored while reading", rxState, 1);
    waitDone(0, n);
    chk("R6 latency unchanged", n + 1, expLat(3, 2, 640));
    tick();
    txReq = 1; txWrite = 1; txLen = 64;
    issue();
    rxReq = 1; rxWrite = 0; rxLen = 64; rxAddr = 32'h4000;
    issue();
    chk("R5 rx read-waiting", rxState, 3);
    rxReq = 1; rxWrite = 1;
    issue();
    chk("R6 other-kind request ignored while waiting", rxState, 3);
    rxReq = 1; rxWrite = 0; rxLen = 640; rxAddr = 32'h5000;
    issue();
    chk("R7 still waiting after refresh", rxState, 3);
    waitDone(1, n);
    tick();
    chk("R7 rx starts", rxState, 1);
    chk("R7 replaced length used", portLen, 640);
    chk("R7 replaced address used", portAddr, 32'h5000);
    waitDone(0, n);
    chk("R7 latency from replaced length", n, expLat(3, 2, 640));
    tick();
  endtask

  task automatic t_long();
    int n;
    rdFactor = 100;
    rxReq = 1; rxWrite = 0; rxLen = 14'd16383;
    issue();
    waitDone(0, n);
    chk("R3 maximum length latency", n, expLat(3, 100, 16383));
    tick();
  endtask

  initial begin
    t_reset();
    t_rx_read();
    t_tx_write();
    t_zero();
    t_simultaneous();
    t_handoff();
    t_ignore();
    t_long();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule